// File: doc/BRIEF.md
# Self-Timed Data-Bus Drive Enable for a Pipelined Common-I/O Memory

This block decides, cycle by cycle, whether a synchronous pipelined memory with a shared data bus may turn its output drivers on. Commands are accepted on a rising clock edge and reach the data phase one accepted edge later. A read uses that data phase to return data. A write uses it to receive data from the bus master. The drive decision is therefore taken from the pipeline's own record of which command occupies the data phase. No turnaround signal from the host is needed. A read may directly follow a write, or a write a read, with no idle cycle and no bus contention.

An active-low output-enable input can only narrow the decision, and it acts without a clock. Three cases force the drivers off whatever that input does: a write data phase, a deselected data phase, and the first data phase that follows a deselected one. A continue-burst command repeats the kind of the last accepted command and ignores the select and write inputs. A suspend input freezes every internal register. After reset the pipeline looks deselected and the drivers are off.

Top module: `oe_drive_ctrl`

## Requirements
- R1: While rst_n is low, and in the first two cycles after its release with only deselects issued, driveEn and wrDataPhase are 0 whatever outEnN is.
- R2: A read accepted at edge k (cmdSel=1, cmdWe=0, cmdAdv=0, hold=0) sets driveEn to 1 during the cycle after the next accepted edge. This requires outEnN=0 and requires that the command accepted just before it was not a deselect.
- R3: A write accepted at edge k sets wrDataPhase to 1 and keeps driveEn at 0 during the cycle after the next accepted edge, whatever outEnN is.
- R4: A deselect accepted at edge k (cmdSel=0, cmdAdv=0) gives driveEn=0 and wrDataPhase=0 in the cycle after the next accepted edge.
- R5: A data phase whose preceding accepted command was a deselect never drives, even for a read with outEnN=0.
- R6: outEnN=1 forces driveEn to 0 at once, with no clock edge needed. Returning outEnN to 0 restores the pipeline's decision.
- R7: An edge with hold=1 changes no internal state. driveEn and wrDataPhase keep their values, except that driveEn still follows outEnN.
- R8: cmdAdv=1 accepts a command of the same kind as the last accepted one, whatever cmdSel and cmdWe are. If the last accepted command was a deselect, the new one is also a deselect.
- R9: driveEn and wrDataPhase are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset to the deselected state |
| hold | input | 1 | 1 suspends the edge: no state changes |
| cmdSel | input | 1 | 1 selects the memory for a new command |
| cmdWe | input | 1 | 1 = write, 0 = read for a new command |
| cmdAdv | input | 1 | 1 = continue the burst with the previous command kind |
| outEnN | input | 1 | Asynchronous active-low output enable |
| driveEn | output | 1 | 1 lets the memory drive the data bus |
| wrDataPhase | output | 1 | 1 during the cycle in which write data is on the bus |

## Verification
The bound checker looks at every cycle. It checks that driving never overlaps a write data phase and that a high output enable always blocks driving. It checks that a suspended edge leaves the write window unchanged. It checks the fixed-latency results of a write, a deselect and a read that directly follows a deselect. The cases that depend on longer command histories are shown only by the bench's exhaustive sweep of command windows, with suspends mixed in and both output-enable levels applied in each cycle. These include bursts that inherit a write or a deselect, reads after writes, and the release from reset.

// File: rtl/oe_drive_pkg.sv
package oe_drive_pkg;

  // Kind of command held in a pipeline stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  // Strobes from the command decoder to the pipeline datapath
  typedef struct packed {
    logic    advance;   // accept the command on this edge
    opKind_e nextOp;    // kind entering the address stage
  } pipeStrobe_t;

endpackage

// File: rtl/oe_drive_dec.sv
module oe_drive_dec
  import oe_drive_pkg::*;
(
  input  logic        hold,
  input  logic        cmdSel,
  input  logic        cmdWe,
  input  logic        cmdAdv,
  input  opKind_e     lastOp,
  output pipeStrobe_t strobe
);

  opKind_e loadOp;
  opKind_e burstOp;

  // A fresh command comes from select and write inputs
  always_comb begin
    if (!cmdSel)     loadOp = OP_IDLE;
    else if (cmdWe)  loadOp = OP_WRITE;
    else             loadOp = OP_READ;
  end

  // A burst continuation inherits the last accepted kind
  assign burstOp = lastOp;

  always_comb begin
    strobe.advance = !hold;
    strobe.nextOp  = cmdAdv ? burstOp : loadOp;
  end

endmodule

// File: rtl/oe_drive_pipe.sv
module oe_drive_pipe
  import oe_drive_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pipeStrobe_t strobe,
  input  logic        outEnN,
  output opKind_e     lastOp,
  output logic        driveEn,
  output logic        wrDataPhase
);

  opKind_e addrStage;
  opKind_e dataStage;
  logic    prevDataIdle;
  logic    syncDrive;

  // Pipeline: address stage -> data stage, plus history bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrStage    <= OP_IDLE;
      dataStage    <= OP_IDLE;
      prevDataIdle <= 1'b1;
    end else if (strobe.advance) begin
      addrStage    <= strobe.nextOp;
      dataStage    <= addrStage;
      prevDataIdle <= (dataStage == OP_IDLE);
    end
  end

  assign lastOp = addrStage;

  // Registered part of the decision, then the asynchronous gate
  assign syncDrive   = (dataStage == OP_READ) && !prevDataIdle;
  assign driveEn     = syncDrive && !outEnN;
  assign wrDataPhase = (dataStage == OP_WRITE);

endmodule

// File: rtl/oe_drive_ctrl.sv
module oe_drive_ctrl
  import oe_drive_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic cmdSel,
  input  logic cmdWe,
  input  logic cmdAdv,
  input  logic outEnN,
  output logic driveEn,
  output logic wrDataPhase
);

  pipeStrobe_t strobe;
  opKind_e     lastOp;

  oe_drive_dec u_dec (
    .hold   (hold),
    .cmdSel (cmdSel),
    .cmdWe  (cmdWe),
    .cmdAdv (cmdAdv),
    .lastOp (lastOp),
    .strobe (strobe)
  );

  oe_drive_pipe u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .outEnN      (outEnN),
    .lastOp      (lastOp),
    .driveEn     (driveEn),
    .wrDataPhase (wrDataPhase)
  );

endmodule

// File: rtl/oe_drive_chk.sv
module oe_drive_chk (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic cmdSel,
  input logic cmdWe,
  input logic cmdAdv,
  input logic outEnN,
  input logic driveEn,
  input logic wrDataPhase
);

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(driveEn && wrDataPhase));

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !driveEn);

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(wrDataPhase));

  // R3
  write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !cmdAdv && cmdSel && cmdWe) ##1 !hold |=> (wrDataPhase && !driveEn));

  // R4
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !cmdAdv && !cmdSel) ##1 !hold |=> (!driveEn && !wrDataPhase));

  // R5
  first_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !cmdAdv && !cmdSel) ##1 (!hold && !cmdAdv && cmdSel) ##1 !hold
      |=> !driveEn);

endmodule

bind oe_drive_ctrl oe_drive_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold        (hold),
  .cmdSel      (cmdSel),
  .cmdWe       (cmdWe),
  .cmdAdv      (cmdAdv),
  .outEnN      (outEnN),
  .driveEn     (driveEn),
  .wrDataPhase (wrDataPhase)
);

// File: tb/sim_oe_drive_ctrl.sv
`timescale 1ns/1ps
module sim_oe_drive_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, cmdSel = 1'b0, cmdWe = 1'b0, cmdAdv = 1'b0, outEnN = 1'b0;
  logic driveEn, wrDataPhase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench history of accepted command kinds: 0 idle, 1 read, 2 write
  int h0 = 0, h1 = 0, h2 = 0;

  always #10 clk = ~clk;

  oe_drive_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .cmdSel(cmdSel), .cmdWe(cmdWe),
    .cmdAdv(cmdAdv), .outEnN(outEnN), .driveEn(driveEn), .wrDataPhase(wrDataPhase)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 burst continue (sel/we junk from junk bits)
  task automatic step(input int kind, input bit hld, input int junk);
    int newOp;
    string tag;
    @(negedge clk);
    hold   = hld;
    outEnN = 1'b0;
    cmdAdv = (kind == 3);
    cmdSel = (kind == 3) ? junk[0] : (kind != 0);
    cmdWe  = (kind == 3) ? junk[1] : (kind == 2);
    @(posedge clk);
    if (!hld) begin
      if (kind == 3) newOp = h0;   // R8: inherit last kind, idle stays idle
      else newOp = kind;
      h2 = h1; h1 = h0; h0 = newOp;
    end
    #2;
    if (hld) tag = "R7";
    else if (kind == 3) tag = "R8";
    else if (h1 == 2) tag = "R3";
    else if (h1 == 0) tag = "R4";
    else if (h2 == 0) tag = "R5";
    else tag = "R2";
    check(tag, wrDataPhase, (h1 == 2), "wrDataPhase");
    check(tag, driveEn, (h1 == 1) && (h2 != 0), "driveEn oe low");
    check("R9", driveEn & wrDataPhase, 1'b0, "overlap");
    #2 outEnN = 1'b1;
    #2 check("R6", driveEn, 1'b0, "driveEn oe high");
    #2 outEnN = 1'b0;
    #1 check("R6", driveEn, (h1 == 1) && (h2 != 0), "driveEn oe restored");
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state for both outEnN levels
    repeat (2) @(posedge clk);
    #2 check("R1", driveEn, 1'b0, "driveEn in reset");
    check("R1", wrDataPhase, 1'b0, "wrDataPhase in reset");
    outEnN = 1'b1;
    #2 check("R1", driveEn, 1'b0, "driveEn in reset oe high");
    outEnN = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    step(0, 1'b0, 0);
    step(0, 1'b0, 0);

    // R8 directed: burst after write with select low keeps writing
    step(2, 1'b0, 0);
    step(3, 1'b0, 0);
    step(3, 1'b0, 1);
    // R8 directed: burst after deselect with read inputs stays deselected
    step(0, 1'b0, 0);
    step(3, 1'b0, 1);
    step(1, 1'b0, 0);
    step(1, 1'b0, 0);
    // R2: read right after write turns around with no gap
    step(2, 1'b0, 0);
    step(1, 1'b0, 0);
    step(1, 1'b0, 0);
    step(0, 1'b0, 0);

    // Exhaustive sweep: every window of four command kinds, holds mixed in
    for (int n = 0; n < 256; n++) begin
      for (int d = 0; d < 4; d++) begin
        int k;
        k = (n >> (2 * d)) & 3;
        step(k, ((n * 4 + d) % 7) == 3, n + d);
      end
    end

    // R7: a run of held edges keeps everything
    step(1, 1'b0, 0);
    step(1, 1'b0, 0);
    step(2, 1'b1, 0);
    step(0, 1'b1, 0);
    step(2, 1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule